// File: doc/BRIEF.md
# Command-Word I2C Bus Master

This block is an I2C controller that runs whole bus transactions from three host registers, with no bit-level control by the host. The host places up to two outgoing bytes in a transmit-data register and then writes a command word. The command word names a 7-bit target, the direction, whether one or two data bytes move, and whether the bus stays owned afterwards. The engine then generates the START (or repeated START), the address byte, the data bytes with their acknowledge bits and, when asked, the STOP. It reports the outcome through sticky event bits in a status word.

A command moves one or two bytes. Longer transfers are built by leaving the bus held and issuing further commands, each of which opens with a repeated START. Read bytes are returned in a receive-data word. SCL and SDA are open-drain: each output is an enable that pulls its line low, and the engine reads the line levels back. A one-byte read without the hold flag is a presence probe of the target.

Top module: `i2c_mbox_master`

## Requirements
- R1: Register selects are 0 for transmit data, 1 for the command word and 2 for status. In the command word the target address sits in bits 7:1, bit 10 = 1 selects a write, bit 11 = 1 requests two data bytes instead of one, and bit 13 = 1 keeps the bus held. A command whose bits 15:14 are not binary 10 is ignored: no bus activity follows and busy stays 0.
- R2: The first byte on the bus is the target address followed by a direction bit (0 = write, 1 = read). It is sent MSB first. A write then sends transmit-data bits 7:0, followed by bits 15:8 when two bytes are requested.
- R3: On a read, the first received byte lands in receive-data bits 7:0 and the second, if requested, in bits 15:8.
- R4: Status bit 15 is the receive-done event, bit 14 the transmit-done event, bit 13 the error event and bit 0 is busy. The event bits are sticky, and writing 1 to an event bit at select 2 clears it. All bits are 0 after reset, with both pad enables released.
- R5: A successful write sets transmit-done and a successful read sets receive-done. A failure sets the error event instead. Exactly one event is raised per command, and it is visible in the cycle that busy returns to 0.
- R6: With hold clear, a command ends with a STOP and leaves both lines high. With hold set and no failure, SCL stays pulled low, SDA is released and no STOP is sent.
- R7: A command on a held bus begins with a repeated START, with no STOP in between. A command on an idle bus begins with a normal START.
- R8: A NACK to the address byte or to any written data byte sets the error event, skips the remaining bytes and always ends with a STOP, even when hold is set.
- R9: On reads, the master ACKs every received byte except the last one of a command without hold, which it NACKs. With hold set, the last byte is also ACKed.
- R10: A one-byte read with hold clear to an address no target answers raises the error event. The same read to an answering target raises receive-done.
- R11: A command-word write while busy is 1 is ignored and starts nothing.
- R12: The SCL high phase lasts 2*CLK_DIV clock cycles when no device holds SCL low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 transmit data, 1 command, 2 status |
| regWdata | input | 16 | Register write data |
| statusWord | output | 16 | Event bits 15:13 and busy bit 0 |
| rxWord | output | 16 | Received bytes |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The hardest cases to reach are the ones where the outcome depends on the target's answer in the middle of a command. Examples are a NACK on the first data byte of a two-byte write that has hold set, and the acknowledge the master gives to the final byte of a held read. The bench attaches a behavioural open-drain target to the lines. Its address can be matched or missed, and it can be told how many written bytes to ACK before it NACKs. It records the start, repeated-start and stop conditions, every byte it receives and every acknowledge bit the master drives. Held-bus chains are formed by issuing a hold command and then a follow-on command without resetting.

// File: rtl/i2c_mbox_pkg.sv
`timescale 1ns/1ps
package i2c_mbox_pkg;

  localparam int REG_TX   = 0;
  localparam int REG_CMD  = 1;
  localparam int REG_STAT = 2;

  localparam int CMD_WR_BIT   = 10;
  localparam int CMD_TWO_BIT  = 11;
  localparam int CMD_HOLD_BIT = 13;
  localparam logic [1:0] MODE_NATIVE = 2'b10;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic dataSel;
    logic shift;
    logic storeRx;
    logic setTx;
    logic setRx;
    logic setErr;
  } mbox_stb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_ACK, S_STOP, S_HELD
  } eng_state_t;

endpackage

// File: rtl/i2c_mbox_dp.sv
`timescale 1ns/1ps
module i2c_mbox_dp
  import i2c_mbox_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWdata,
  input  logic        busy,
  input  mbox_stb_t   stb,
  input  logic        sdaIn,
  output logic        cmdGo,
  output logic [9:0]  cmdFields,
  output logic        shMsb,
  output logic        tick,
  output logic [2:0]  evBits,
  output logic [15:0] rxWord
);

  localparam int CW = $clog2(CLK_DIV + 1);

  logic [CW-1:0] divCnt;
  logic [15:0]   txReg;
  logic [7:0]    shReg;
  logic [2:0]    setVec;
  logic [2:0]    clrVec;

  assign tick  = (divCnt == CW'(CLK_DIV - 1));
  assign cmdGo = regWe && (regSel == 2'(REG_CMD)) && !busy &&
                 (regWdata[15:14] == MODE_NATIVE);
  assign shMsb = shReg[7];

  assign setVec = {stb.setRx, stb.setTx, stb.setErr};
  assign clrVec = (regWe && regSel == 2'(REG_STAT)) ? regWdata[15:13] : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg     <= '0;
      cmdFields <= '0;
    end else begin
      if (regWe && regSel == 2'(REG_TX)) txReg <= regWdata;
      if (cmdGo)
        cmdFields <= {regWdata[CMD_HOLD_BIT], regWdata[CMD_TWO_BIT],
                      regWdata[CMD_WR_BIT], regWdata[7:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (stb.loadAddr) shReg <= {cmdFields[6:0], ~cmdFields[7]};
    else if (stb.loadData) shReg <= stb.dataSel ? txReg[15:8] : txReg[7:0];
    else if (stb.shift) shReg <= {shReg[6:0], sdaIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxWord <= '0;
    else if (stb.storeRx) begin
      if (stb.dataSel) rxWord[15:8] <= shReg;
      else rxWord[7:0] <= shReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evBits <= '0;
    else evBits <= (evBits & ~clrVec) | setVec;
  end

endmodule

// File: rtl/i2c_mbox_ctrl.sv
`timescale 1ns/1ps
module i2c_mbox_ctrl
  import i2c_mbox_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      cmdGo,
  input  logic      cmdWrite,
  input  logic      cmdTwo,
  input  logic      cmdHold,
  input  logic      shMsb,
  input  logic      sclIn,
  input  logic      sdaIn,
  output mbox_stb_t stb,
  output logic      busy,
  output logic      sclOe,
  output logic      sdaOe
);

  eng_state_t state;
  logic [1:0] q;
  logic [2:0] bitCnt;
  logic [1:0] byteIdx;
  logic       failed;

  logic lastByte, reading, running, stall, advance;

  assign lastByte = (byteIdx == (cmdTwo ? 2'd2 : 2'd1));
  assign reading  = (byteIdx != 2'd0) && !cmdWrite;
  assign running  = (state == S_START) || (state == S_BIT) ||
                    (state == S_ACK) || (state == S_STOP);
  assign stall    = running && (q == 2'd2) && !sclIn;
  assign advance  = tick && running && !stall;
  assign busy     = running;

  always_comb begin
    stb = '0;
    if (advance) begin
      unique case (state)
        S_START: if (q == 2'd3) stb.loadAddr = 1'b1;
        S_BIT:   if (q == 2'd2) stb.shift = 1'b1;
        S_ACK: begin
          if (q == 2'd2 && reading) begin
            stb.storeRx = 1'b1;
            stb.dataSel = (byteIdx == 2'd2);
          end
          if (q == 2'd3 && !failed) begin
            if (!lastByte && cmdWrite) begin
              stb.loadData = 1'b1;
              stb.dataSel  = (byteIdx == 2'd1);
            end
            if (lastByte && cmdHold) begin
              stb.setTx = cmdWrite;
              stb.setRx = !cmdWrite;
            end
          end
        end
        S_STOP: if (q == 2'd3) begin
          stb.setErr = failed;
          stb.setTx  = !failed && cmdWrite;
          stb.setRx  = !failed && !cmdWrite;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      q       <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      failed  <= 1'b0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          sclOe <= 1'b0;
          sdaOe <= 1'b0;
          if (cmdGo) begin
            state  <= S_START;
            q      <= '0;
            failed <= 1'b0;
          end
        end
        S_HELD: begin
          if (cmdGo) begin
            state  <= S_START;
            q      <= '0;
            failed <= 1'b0;
          end else if (tick) sdaOe <= 1'b0;
        end
        default: if (advance) begin
          q <= q + 2'd1;
          unique case (state)
            S_START: unique case (q)
              2'd0: sdaOe <= 1'b0;
              2'd1: sclOe <= 1'b0;
              2'd2: sdaOe <= 1'b1;
              default: begin
                sclOe   <= 1'b1;
                state   <= S_BIT;
                bitCnt  <= 3'd7;
                byteIdx <= 2'd0;
              end
            endcase
            S_BIT: unique case (q)
              2'd0: sdaOe <= reading ? 1'b0 : ~shMsb;
              2'd1: sclOe <= 1'b0;
              2'd2: ;
              default: begin
                sclOe <= 1'b1;
                if (bitCnt == 3'd0) state <= S_ACK;
                else bitCnt <= bitCnt - 3'd1;
              end
            endcase
            S_ACK: unique case (q)
              2'd0: sdaOe <= reading && !(lastByte && !cmdHold);
              2'd1: sclOe <= 1'b0;
              2'd2: if (!reading && sdaIn) failed <= 1'b1;
              default: begin
                sclOe <= 1'b1;
                if (failed) state <= S_STOP;
                else if (lastByte) state <= cmdHold ? S_HELD : S_STOP;
                else begin
                  byteIdx <= byteIdx + 2'd1;
                  bitCnt  <= 3'd7;
                  state   <= S_BIT;
                end
              end
            endcase
            default: unique case (q)
              2'd0: begin
                sclOe <= 1'b1;
                sdaOe <= 1'b1;
              end
              2'd1: sclOe <= 1'b0;
              2'd2: sdaOe <= 1'b0;
              default: state <= S_IDLE;
            endcase
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_mbox_master.sv
`timescale 1ns/1ps
module i2c_mbox_master
  import i2c_mbox_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWdata,
  output logic [15:0] statusWord,
  output logic [15:0] rxWord,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe
);

  mbox_stb_t  stb;
  logic       cmdGo;
  logic [9:0] cmdFields;
  logic       shMsb;
  logic       tick;
  logic       busy;
  logic [2:0] evBits;

  assign statusWord = {evBits, 12'd0, busy};

  i2c_mbox_dp #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .busy(busy), .stb(stb), .sdaIn(sdaIn),
    .cmdGo(cmdGo), .cmdFields(cmdFields), .shMsb(shMsb), .tick(tick),
    .evBits(evBits), .rxWord(rxWord)
  );

  i2c_mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdGo(cmdGo),
    .cmdWrite(cmdFields[7]), .cmdTwo(cmdFields[8]), .cmdHold(cmdFields[9]),
    .shMsb(shMsb), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb), .busy(busy),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/i2c_mbox_checker.sv
`timescale 1ns/1ps
module i2c_mbox_checker
  import i2c_mbox_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [2:0] evBits,
  input logic       cmdGo,
  input logic [9:0] cmdFields,
  input mbox_stb_t  stb
);

  AST_GO_STARTS_ENGINE: assert property (@(posedge clk) disable iff (!rstN)
    cmdGo |=> busy); // R1

  AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdFields)); // R11

  AST_ONE_SET_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setTx, stb.setRx, stb.setErr})); // R5

  AST_DONE_HAS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (evBits != 3'b000)); // R5

  AST_NEW_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evBits & ~$past(evBits))); // R5

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(stb.shift || stb.loadAddr || stb.storeRx)); // R1

  AST_RX_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeRx |-> !cmdFields[7]); // R3

  AST_SECOND_BYTE_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadData && stb.dataSel) |-> cmdFields[8]); // R2

endmodule

bind i2c_mbox_master i2c_mbox_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .evBits(evBits),
  .cmdGo(cmdGo), .cmdFields(cmdFields), .stb(stb)
);

// File: tb/i2c_mbox_master_bench.sv
`timescale 1ns/1ps
module i2c_mbox_master_bench;

  localparam int CLK_DIV = 4;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] statusWord, rxWord;
  logic sclOe, sdaOe;
  logic tgtSdaLow = 1'b0;
  wire sclLine = !sclOe;
  wire sdaLine = !(sdaOe || tgtSdaLow);

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  i2c_mbox_master #(.CLK_DIV(CLK_DIV)) u_i2c_mbox_master (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .statusWord(statusWord), .rxWord(rxWord),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // ---------------- behavioural target ----------------
  typedef enum {T_OFF, T_ADDR, T_WR, T_RD} tst_t;
  tst_t tState = T_OFF;
  int bitPos = 0;
  logic [7:0] tSh = 8'd0;
  logic tAcked = 1'b0;
  logic tRd = 1'b0;
  logic busBusy = 1'b0;
  int startCnt = 0, rsCnt = 0, stopCnt = 0;
  int wrCount = 0, ackCnt = 0, rdIdx = 0, ackLimit = 100;
  logic [7:0] addrLog = 8'd0;
  logic [7:0] wrLog [8];
  logic ackLog [8];
  logic [7:0] rdBytes [4] = '{8'hA5, 8'h3C, 8'h96, 8'h0F};
  longint tRise = 0, lastHigh = 0;

  always @(negedge sdaLine) if (sclLine === 1'b1) begin
    startCnt++;
    if (busBusy) rsCnt++;
    busBusy = 1'b1;
    tState = T_ADDR;
    bitPos = 0;
    tgtSdaLow = 1'b0;
  end

  always @(posedge sdaLine) if (sclLine === 1'b1) begin
    stopCnt++;
    busBusy = 1'b0;
    tState = T_OFF;
    tgtSdaLow = 1'b0;
  end

  always @(posedge sclLine) begin
    tRise = $time;
    case (tState)
      T_ADDR, T_WR: begin
        if (bitPos < 8) tSh = {tSh[6:0], sdaLine};
        bitPos++;
      end
      T_RD: begin
        if (bitPos == 8 && ackCnt < 8) begin
          ackLog[ackCnt] = !sdaLine;
          ackCnt++;
        end
        bitPos++;
      end
      default: ;
    endcase
  end

  always @(negedge sclLine) begin
    lastHigh = $time - tRise;
    case (tState)
      T_ADDR, T_WR: begin
        if (bitPos == 8) begin
          if (tState == T_ADDR) begin
            addrLog = tSh;
            tAcked = (tSh[7:1] == TGT);
            tRd = tSh[0];
            rdIdx = 0;
          end else begin
            if (wrCount < 8) wrLog[wrCount] = tSh;
            wrCount++;
            tAcked = (wrCount <= ackLimit);
          end
          tgtSdaLow = tAcked;
        end else if (bitPos == 9) begin
          tgtSdaLow = 1'b0;
          bitPos = 0;
          if (!tAcked) tState = T_OFF;
          else if (tState == T_ADDR) begin
            if (tRd) begin
              tState = T_RD;
              tgtSdaLow = !rdBytes[rdIdx][7];
            end else tState = T_WR;
          end
        end
      end
      T_RD: begin
        if (bitPos >= 1 && bitPos <= 7) tgtSdaLow = !rdBytes[rdIdx][7-bitPos];
        else if (bitPos == 8) tgtSdaLow = 1'b0;
        else if (bitPos == 9) begin
          if (ackLog[ackCnt-1] && rdIdx < 3) begin
            rdIdx++;
            bitPos = 0;
            tgtSdaLow = !rdBytes[rdIdx][7];
          end else begin
            tState = T_OFF;
            tgtSdaLow = 1'b0;
          end
        end
      end
      default: ;
    endcase
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regSel = sel;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitIdle();
    int cnt = 0;
    repeat (3) @(negedge clk);
    while (statusWord[0] && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    checks++;
    if (cnt >= 20000) begin
      failures++;
      $display("FAIL R5 actual=busy expected=idle");
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic runCmd(input logic [15:0] tx, input logic [15:0] cmd);
    regWrite(2'd2, 16'hE000);
    regWrite(2'd0, tx);
    regWrite(2'd1, cmd);
    waitIdle();
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [15:0] tx;
    logic [15:0] cmd;
    logic [2:0]  ev;
    logic [15:0] rx;
    logic [15:0] rxMask;
  } vec_t;

  // cmd: 0x8000 mode, 0x0400 write, 0x0800 two bytes, addr<<1; ev = {rx,tx,err}
  localparam vec_t VECS [6] = '{
    '{16'h0011, 16'h84A0, 3'b010, 16'h0000, 16'h0000},
    '{16'h2211, 16'h8CA0, 3'b010, 16'h0000, 16'h0000},
    '{16'h0000, 16'h80A0, 3'b100, 16'h00A5, 16'h00FF},
    '{16'h0000, 16'h88A0, 3'b100, 16'h3CA5, 16'hFFFF},
    '{16'h0000, 16'h8042, 3'b001, 16'h0000, 16'h0000},
    '{16'h0000, 16'h8442, 3'b001, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sc, ss, sr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startCnt = 0; rsCnt = 0; stopCnt = 0; busBusy = 1'b0; tState = T_OFF;

    // R4 reset state
    check("R4 reset status", 32'(statusWord), 32'h0);
    check("R4 reset rx", 32'(rxWord), 32'h0);
    check("R4 reset pads", {30'd0, sclOe, sdaOe}, 32'h0);

    // table walk: R3 R5 R6 R10
    for (int i = 0; i < 6; i++) begin
      runCmd(VECS[i].tx, VECS[i].cmd);
      check(i >= 4 ? "R10 event" : "R5 event", 32'(statusWord[15:13]), 32'(VECS[i].ev));
      check("R3 rx data", 32'(rxWord & VECS[i].rxMask), 32'(VECS[i].rx));
      check("R6 bus released", {29'd0, sclLine, sdaLine, busBusy}, 32'h6);
    end

    // R12 SCL high phase width
    check("R12 scl high", 32'(lastHigh), 32'(2 * CLK_DIV * 8));

    // R1 wrong mode ignored
    sc = startCnt;
    regWrite(2'd1, 16'h44A0);
    repeat (40) @(negedge clk);
    check("R1 bad mode busy", 32'(statusWord[0]), 32'h0);
    check("R1 bad mode start", 32'(startCnt), 32'(sc));

    // R11 command while busy ignored
    regWrite(2'd2, 16'hE000);
    regWrite(2'd0, 16'h0044);
    sc = startCnt;
    regWrite(2'd1, 16'h84A0);
    regWrite(2'd1, 16'h80A0);
    waitIdle();
    repeat (100) @(negedge clk);
    check("R11 only first event", 32'(statusWord[15:13]), 32'h2);
    check("R11 one start", 32'(startCnt), 32'(sc + 1));

    // R2 byte order and address byte
    wrCount = 0;
    runCmd(16'hC35A, 16'h8CA0);
    check("R2 address byte write", 32'(addrLog), 32'hA0);
    check("R2 first data byte", 32'(wrLog[0]), 32'h5A);
    check("R2 second data byte", 32'(wrLog[1]), 32'hC3);
    runCmd(16'h0000, 16'h80A0);
    check("R2 address byte read", 32'(addrLog), 32'hA1);

    // R6 R7 held bus then repeated start
    ss = stopCnt; sr = rsCnt;
    runCmd(16'h0077, 16'hA4A0);
    check("R6 held event", 32'(statusWord[15:13]), 32'h2);
    check("R6 no stop while held", 32'(stopCnt), 32'(ss));
    check("R6 scl held low", {30'd0, sclLine, busBusy}, 32'h1);
    regWrite(2'd1, 16'h80A0);
    waitIdle();
    check("R7 repeated start", 32'(rsCnt), 32'(sr + 1));
    check("R7 rx after restart", 32'(rxWord[7:0]), 32'hA5);
    check("R6 stop after chain", 32'(stopCnt), 32'(ss + 1));

    // R4 write-1-to-clear, events tx and rx both set now
    check("R4 both sticky", 32'(statusWord[15:13]), 32'h6);
    regWrite(2'd2, 16'h4000);
    @(negedge clk);
    check("R4 clear tx only", 32'(statusWord[15:13]), 32'h4);
    regWrite(2'd2, 16'h8000);
    @(negedge clk);
    check("R4 clear rx", 32'(statusWord[15:13]), 32'h0);

    // R8 data NACK with hold: abort and STOP
    ackLimit = 0; wrCount = 0; ss = stopCnt;
    runCmd(16'h7766, 16'hACA0);
    check("R8 data nack error", 32'(statusWord[15:13]), 32'h1);
    check("R8 second byte skipped", 32'(wrCount), 32'h1);
    check("R8 stop despite hold", 32'(stopCnt), 32'(ss + 1));
    ackLimit = 100;
    ss = stopCnt;
    runCmd(16'h0000, 16'hA442);
    check("R8 address nack error", 32'(statusWord[15:13]), 32'h1);
    check("R8 address nack stop", {31'd0, sclLine && sdaLine}, 32'h1);
    check("R8 address nack stop count", 32'(stopCnt), 32'(ss + 1));

    // R9 acknowledge pattern on reads
    ackCnt = 0;
    runCmd(16'h0000, 16'h88A0);
    check("R9 first byte acked", 32'(ackLog[0]), 32'h1);
    check("R9 last byte nacked", 32'(ackLog[1]), 32'h0);
    ackCnt = 0;
    runCmd(16'h0000, 16'hA8A0);
    check("R9 held first ack", 32'(ackLog[0]), 32'h1);
    check("R9 held last ack", 32'(ackLog[1]), 32'h1);
    check("R9 held rx event", 32'(statusWord[15:13]), 32'h4);
    check("R9 held scl low", 32'(sclLine), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule